// File: doc/BRIEF.md
# Frame Transmit Sequencer with Delimiter Timing Output

This block runs one packet-radio frame out of a byte transmit path after a single start strobe. After a start, it waits through a programmable lead-in. It then emits a synthetic preamble and the start-of-frame delimiter on its own. Next it forwards the length byte and the payload bytes from a first-word-fall-through transmit FIFO. It closes the frame with a CRC-16 that it computes from the payload as the bytes pass. Bytes leave on a valid/ready stream toward a modulator.

A timing output marks the frame body. It becomes active once the delimiter byte has been accepted. It goes inactive after the last CRC byte is accepted, or when the frame is aborted because the FIFO ran dry. A configuration input selects the polarity of this output. A host can wire it to a timer capture input to timestamp transmissions.

Top module: `frame_tx_seq`

## Requirements
- R1: A start strobe seen while idle sets busy and begins a lead-in of exactly LEADIN_CYCLES clock cycles during which no byte is offered; the first preamble byte is offered right after.
- R2: The frame opens with PREAMBLE_BYTES bytes of value 0x00 followed by one delimiter byte of value 0xA7, all generated internally without touching the FIFO.
- R3: The first FIFO byte is the length field and is sent right after the delimiter; then max(length,2)-2 payload bytes are read from the FIFO and sent in FIFO order; each FIFO byte is popped in the same cycle it is accepted downstream.
- R4: The two final bytes are a CRC-16 with polynomial x^16+x^12+x^5+1, initial value 0, bits taken LSB first, computed over the payload bytes only (not the length), sent low byte first.
- R5: While a byte is offered and not accepted, the offered byte stays unchanged and the FIFO is not popped.
- R6: The frame-timing indication is active from the cycle after the delimiter byte is accepted until the cycle after the last CRC byte is accepted, and is inactive during lead-in, preamble and delimiter.
- R7: With sfd_pol_i = 0 the timing output is high when active; with sfd_pol_i = 1 it is inverted, so it sits high while idle.
- R8: If the FIFO is empty when the length or a payload byte is due, no byte is offered, underflow_o is high for exactly one cycle, and in the next cycle the block is idle with the timing indication inactive and nothing further popped.
- R9: A start strobe arriving while busy is ignored: the frame in progress is unchanged and no second frame follows.
- R10: Length values 0, 1 and 2 carry no payload; the frame is preamble, delimiter, length byte and CRC 0x0000.
- R11: After reset the block is idle: busy_o, tx_valid_o, fifo_pop_o and underflow_o are low and the timing output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-transmission strobe |
| sfd_pol_i | input | 1 | Timing output polarity, 1 inverts |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| fifo_pop_o | output | 1 | Remove the head byte from the FIFO |
| tx_data_o | output | 8 | Byte toward the modulator |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_ready_i | input | 1 | Modulator accepts the byte |
| sfd_o | output | 1 | Frame-timing output |
| underflow_o | output | 1 | One-cycle pulse on FIFO underflow abort |
| busy_o | output | 1 | Frame in progress |

## Verification
Every cycle, the assertions check several properties. A pop happens only on an accepted byte with data present. A stalled byte is held steady. The timing indication rises only right after the delimiter is accepted, and it falls only after an accepted byte or an underflow. An underflow leaves the block idle. The lead-in counter stays within its bound, and the CRC register clears and holds as commanded. The exact byte order, the CRC values, the lead-in length, the polarity levels, short-length handling and the ignored start strobes are properties of whole frames, so only the bench's frame scenarios can show them.

// File: rtl/ftx_pkg.sv
`timescale 1ns/1ps
package ftx_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_LSBF = 16'h8408; // x^16+x^12+x^5+1, reflected

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEADIN, ST_PREAMBLE, ST_DELIM,
    ST_LENGTH, ST_PAYLOAD, ST_CRC_LO, ST_CRC_HI
  } ftx_state_e;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, byte_t d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_LSBF;
    end
    return r;
  endfunction
endpackage

// File: rtl/ftx_leadin.sv
`timescale 1ns/1ps
module ftx_leadin #(
  parameter int CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  p_leadin_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/ftx_crc16.sv
`timescale 1ns/1ps
module ftx_crc16 import ftx_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  byte_t            data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_step(crc_q, data_i);
  end

  assign crc_o = crc_q;

  p_crc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == '0));
  p_crc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/ftx_bytecnt.sv
`timescale 1ns/1ps
module ftx_bytecnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));

  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/frame_tx_seq.sv
`timescale 1ns/1ps
module frame_tx_seq import ftx_pkg::*; #(
  parameter int          LEADIN_CYCLES  = 12,
  parameter int          PREAMBLE_BYTES = 4,
  parameter logic [7:0]  PREAMBLE_VAL   = 8'h00,
  parameter logic [7:0]  DELIM_VAL      = 8'hA7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sfd_pol_i,
  input  logic [7:0] fifo_data_i,
  input  logic       fifo_empty_i,
  output logic       fifo_pop_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic       sfd_o,
  output logic       underflow_o,
  output logic       busy_o
);
  localparam int PRE_CW = (PREAMBLE_BYTES > 1) ? $clog2(PREAMBLE_BYTES) : 1;
  localparam logic [PRE_CW-1:0] PRE_LAST = PRE_CW'(PREAMBLE_BYTES - 1);
  localparam byte_t CRC_BYTES = byte_t'(2);

  ftx_state_e       state_q, state_d;
  logic [PRE_CW-1:0] pre_cnt_q;
  logic             xfer, from_fifo, uflow, sfd_act;
  logic             lead_done, pay_last, has_payload;
  logic [CRC_W-1:0] crc;

  assign from_fifo   = (state_q == ST_LENGTH) || (state_q == ST_PAYLOAD);
  assign uflow       = from_fifo && fifo_empty_i;
  assign tx_valid_o  = (state_q inside {ST_PREAMBLE, ST_DELIM, ST_LENGTH,
                                        ST_PAYLOAD, ST_CRC_LO, ST_CRC_HI}) && !uflow;
  assign xfer        = tx_valid_o && tx_ready_i;
  assign fifo_pop_o  = from_fifo && xfer;
  assign sfd_act     = state_q inside {ST_LENGTH, ST_PAYLOAD, ST_CRC_LO, ST_CRC_HI};
  assign sfd_o       = sfd_act ^ sfd_pol_i;
  assign underflow_o = uflow;
  assign busy_o      = (state_q != ST_IDLE);
  assign has_payload = (fifo_data_i > CRC_BYTES);

  always_comb begin
    unique case (state_q)
      ST_PREAMBLE:          tx_data_o = PREAMBLE_VAL;
      ST_DELIM:             tx_data_o = DELIM_VAL;
      ST_LENGTH, ST_PAYLOAD: tx_data_o = fifo_data_i;
      ST_CRC_LO:            tx_data_o = crc[7:0];
      ST_CRC_HI:            tx_data_o = crc[15:8];
      default:              tx_data_o = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_LEADIN;
      ST_LEADIN:   if (lead_done) state_d = ST_PREAMBLE;
      ST_PREAMBLE: if (xfer && pre_cnt_q == PRE_LAST) state_d = ST_DELIM;
      ST_DELIM:    if (xfer) state_d = ST_LENGTH;
      ST_LENGTH: begin
        if (uflow)     state_d = ST_IDLE;
        else if (xfer) state_d = has_payload ? ST_PAYLOAD : ST_CRC_LO;
      end
      ST_PAYLOAD: begin
        if (uflow)                 state_d = ST_IDLE;
        else if (xfer && pay_last) state_d = ST_CRC_LO;
      end
      ST_CRC_LO:   if (xfer) state_d = ST_CRC_HI;
      ST_CRC_HI:   if (xfer) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_cnt_q <= '0;
    else if (state_q != ST_PREAMBLE) pre_cnt_q <= '0;
    else if (xfer)                  pre_cnt_q <= pre_cnt_q + 1'b1;
  end

  ftx_leadin #(.CYCLES(LEADIN_CYCLES)) u_leadin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_LEADIN),
    .done_o (lead_done)
  );

  ftx_bytecnt #(.W(BYTE_W)) u_paycnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     ((state_q == ST_LENGTH) && xfer),
    .load_val_i (fifo_data_i - CRC_BYTES),
    .dec_i      ((state_q == ST_PAYLOAD) && xfer),
    .last_o     (pay_last)
  );

  ftx_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .en_i   ((state_q == ST_PAYLOAD) && xfer),
    .data_i (fifo_data_i),
    .crc_o  (crc)
  );

  p_pop_on_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (!fifo_empty_i && tx_ready_i && tx_valid_o));
  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  p_sfd_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sfd_act) |-> $past(xfer && tx_data_o == DELIM_VAL));
  p_sfd_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sfd_act) |-> ($past(underflow_o) || $past(xfer)));
  p_uflow_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> (!busy_o && !sfd_act && !underflow_o));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_valid_o && !fifo_pop_o));
endmodule

// File: tb/sim_frame_tx_seq.sv
`timescale 1ns/1ps
module sim_frame_tx_seq;
  localparam int LEADIN = 12;
  localparam int PRE    = 4;
  // {length, payload seed, ready stall mask, polarity}
  localparam logic [31:0] VEC [0:5] = '{
    32'h0C_31_00_00, 32'h03_5A_55_00, 32'h14_C3_0F_01,
    32'h02_00_92_00, 32'h01_77_00_01, 32'h00_10_24_00
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pol = 1'b0;
  logic [7:0] fifo_data;
  logic       fifo_empty, fifo_pop;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic       sfd, uflow, busy;

  int nchk = 0, nerr = 0;

  frame_tx_seq #(.LEADIN_CYCLES(LEADIN), .PREAMBLE_BYTES(PRE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sfd_pol_i(pol),
    .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty), .fifo_pop_o(fifo_pop),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .sfd_o(sfd), .underflow_o(uflow), .busy_o(busy)
  );

  // FIFO model
  logic [7:0] mem [0:1023];
  int rd = 0, wr = 0;
  assign fifo_empty = (rd == wr);
  assign fifo_data  = mem[rd & 1023];
  always @(posedge clk) if (fifo_pop) rd <= rd + 1;

  // downstream model and capture
  logic [7:0] cap [0:511];
  bit         cap_sfd [0:511];
  int         ncap = 0, uf_cnt = 0, cyc = 0;
  logic [7:0] rmask = 8'h00;
  always @(negedge clk) begin
    tx_ready = ~rmask[cyc & 7];
    cyc++;
    if (tx_valid && tx_ready) begin
      cap[ncap & 511]     = tx_data;
      cap_sfd[ncap & 511] = sfd ^ pol;
      ncap++;
    end
    if (uflow) uf_cnt++;
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(logic [7:0] seed, int i);
    return seed + 8'(i * 29);
  endfunction

  function automatic logic [15:0] ref_crc(logic [7:0] seed, int n);
    logic [15:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pay_byte(seed, i);
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ d[j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic load(int len, int npay, logic [7:0] seed);
    mem[wr & 1023] = 8'(len); wr++;
    for (int i = 0; i < npay; i++) begin
      mem[wr & 1023] = pay_byte(seed, i); wr++;
    end
  endtask

  task automatic kick_and_leadin(string req);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!tx_valid && n < 1000) begin n++; @(negedge clk); end
    chk(req, "lead-in cycles", n, LEADIN);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin t++; @(negedge clk); end
    chk("R3", "frame ends", int'(busy), 0);
  endtask

  task automatic check_frame(int len, logic [7:0] seed, int npay);
    logic [15:0] c = ref_crc(seed, npay);
    int total = PRE + 2 + npay + 2;
    chk("R3", "byte count", ncap, total);
    for (int i = 0; i < total && i < ncap; i++) begin
      logic [7:0] e;
      string r;
      if (i < PRE)                 begin e = 8'h00; r = "R2"; end
      else if (i == PRE)           begin e = 8'hA7; r = "R2"; end
      else if (i == PRE + 1)       begin e = 8'(len); r = "R3"; end
      else if (i < PRE + 2 + npay) begin e = pay_byte(seed, i - PRE - 2); r = "R3"; end
      else if (i == PRE + 2 + npay) begin e = c[7:0]; r = "R4"; end
      else                         begin e = c[15:8]; r = "R4"; end
      chk(r, $sformatf("byte %0d", i), cap[i], e);
      chk("R6", $sformatf("sfd at byte %0d", i), int'(cap_sfd[i]), int'(i > PRE));
    end
    chk("R6", "sfd after frame", int'(sfd), int'(pol));
    chk("R3", "fifo drained", rd, wr);
  endtask

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "busy in reset", int'(busy), 0);
    chk("R11", "valid in reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "valid", int'(tx_valid), 0);
    chk("R11", "pop", int'(fifo_pop), 0);
    chk("R11", "underflow", int'(uflow), 0);
    chk("R11", "sfd idle", int'(sfd), 0);

    // table of frames: R1 R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < 6; v++) begin
      int len  = int'(VEC[v][31:24]);
      logic [7:0] seed = VEC[v][23:16];
      int npay = (len > 2) ? len - 2 : 0;
      rmask = VEC[v][15:8];
      pol   = VEC[v][0];
      @(negedge clk);
      chk("R7", "idle level for polarity", int'(sfd), int'(pol));
      ncap = 0;
      load(len, npay, seed);
      kick_and_leadin("R1");
      wait_idle();
      check_frame(len, seed, npay);
      if (len <= 2) chk("R10", "short length payload", ncap, PRE + 4);
    end

    // R8 underflow during payload
    pol = 1'b0; rmask = 8'h00; ncap = 0; uf_cnt = 0;
    load(10, 3, 8'h44);
    kick_and_leadin("R1");
    wait_idle();
    chk("R8", "bytes before abort", ncap, PRE + 5);
    chk("R8", "underflow pulses", uf_cnt, 1);
    chk("R8", "sfd after abort", int'(sfd), 0);
    chk("R8", "no extra pop", rd, wr);

    // R8 underflow at length byte
    ncap = 0; uf_cnt = 0; pol = 1'b1;
    kick_and_leadin("R1");
    wait_idle();
    chk("R8", "bytes before abort at length", ncap, PRE + 1);
    chk("R8", "underflow pulses at length", uf_cnt, 1);
    chk("R8", "sfd after abort at length", int'(sfd), 1);

    // R9 start while busy, in lead-in and in payload
    pol = 1'b0; ncap = 0;
    load(8, 6, 8'h9D);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (ncap < PRE + 4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    check_frame(8, 8'h9D, 6);
    repeat (30) @(negedge clk);
    chk("R9", "no second frame busy", int'(busy), 0);
    chk("R9", "no second frame bytes", ncap, PRE + 10);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule